// File: doc/BRIEF.md
# Dual-output level interrupt controller

This block gathers up to 32 level-sensitive interrupt sources and drives two request lines to a processor. One is the normal interrupt request and the other is the fast interrupt request. Each line has its own enable mask over the same set of raw sources. A mask is never written whole. One word address ORs ones into it and a second address removes the bits that are set in the written data, so separate software agents can change their own bits without a read-modify-write.

Source 0 also has a software latch. A write can set or clear it, and hardware input 0 is ORed with it. Software reads the raw levels, each mask, and the masked status for each line through a word-indexed register bus. A read returns its data one cycle after the request. Both request lines come from flops and follow the state one cycle later. The block has no priority, no vectoring and no edge capture.

The register decode is a pure index compare and has no sequencing state. Its outcomes are the named selections NONE, IRQ_MSKD, RAW, IRQ_MASK, SOFT, FIQ_MSKD and FIQ_MASK. It also produces six write strobes: IRQ set, IRQ clear, FIQ set, FIQ clear, soft set and soft clear.

Top module: `dual_intc`

## Requirements
- R1: After reset, both masks and the software latch are zero, `irq_o` and `fiq_o` are low, and `bus_rdata` is zero.
- R2: Writing index 2 ORs `bus_wdata` into the IRQ mask. Writing index 3 clears the IRQ mask bits that are one in `bus_wdata`. Reading index 2 returns the IRQ mask.
- R3: Writing index 10 ORs `bus_wdata` into the FIQ mask. Writing index 11 clears the FIQ mask bits that are one in `bus_wdata`. Reading index 10 returns the FIQ mask.
- R4: Reading index 1 or index 9 returns the raw level word. Raw bits 31..1 equal `src_i[31:1]`, and raw bit 0 is `src_i[0]` OR the software latch.
- R5: Reading index 0 returns raw AND IRQ mask, and reading index 8 returns raw AND FIQ mask.
- R6: A write to index 4 with data bit 0 set sets the software latch. A write to index 5 with data bit 0 set clears it. Either write with bit 0 clear has no effect. Reading index 4 returns raw bit 0 in bit 0 and zero in every other bit.
- R7: `irq_o` is high in the cycle after one in which (raw AND IRQ mask) is nonzero. After a mask write, the line changes one clock edge after the edge that stored the mask.
- R8: `fiq_o` is high in the cycle after one in which (raw AND FIQ mask) is nonzero.
- R9: Reads of indices 3, 5 and 11 and of unmapped indices return zero. Writes to indices 0, 1, 8, 9 and to unmapped indices change no state.
- R10: `bus_rdata` is loaded on the clock edge that samples `bus_rd` and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Level interrupt sources |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_idx | input | IDX_W | Word index of the register |
| bus_wdata | input | NSRC | Write data |
| bus_rdata | output | NSRC | Read data, registered |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The assertions take it for granted that `bus_wr` and `bus_rd` are never high in the same cycle. With both high, a read could see a value that the same edge is about to change. The output checks also assume that `src_i` is driven to a known level in every cycle. The stimulus changes sources and strobes only on the falling edge, issues one access per step, and gives each access a full idle cycle before sampling. As a result, every property sees one clean operation at a time.

// File: rtl/dual_intc_pkg.sv
package dual_intc_pkg;

    // Register word indices; software depends on these positions.
    localparam int IX_IRQ_MSKD = 0;
    localparam int IX_IRQ_RAW  = 1;
    localparam int IX_IRQ_SET  = 2;
    localparam int IX_IRQ_CLR  = 3;
    localparam int IX_SOFT_SET = 4;
    localparam int IX_SOFT_CLR = 5;
    localparam int IX_FIQ_MSKD = 8;
    localparam int IX_FIQ_RAW  = 9;
    localparam int IX_FIQ_SET  = 10;
    localparam int IX_FIQ_CLR  = 11;

    localparam int NUM_LINES = 2;
    localparam int LINE_IRQ  = 0;
    localparam int LINE_FIQ  = 1;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_IRQ_MSKD,
        SEL_RAW,
        SEL_IRQ_MASK,
        SEL_SOFT,
        SEL_FIQ_MSKD,
        SEL_FIQ_MASK
    } rd_sel_e;

    typedef struct packed {
        logic [NUM_LINES-1:0] mask_set;
        logic [NUM_LINES-1:0] mask_clr;
        logic                 soft_set;
        logic                 soft_clr;
    } wr_strobe_t;

endpackage

// File: rtl/intc_decode.sv
module intc_decode
    import dual_intc_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             wr,
    input  logic [IDX_W-1:0] idx,
    input  logic             wbit0,
    output rd_sel_e          rd_sel,
    output wr_strobe_t       wstb
);

    localparam int NREG = 1 << IDX_W;

    function automatic logic hit(input logic [IDX_W-1:0] a, input int code);
        return (code < NREG) && (int'(a) == code);
    endfunction

    always_comb begin
        rd_sel = SEL_NONE;
        if (hit(idx, IX_IRQ_MSKD))      rd_sel = SEL_IRQ_MSKD;
        else if (hit(idx, IX_IRQ_RAW))  rd_sel = SEL_RAW;
        else if (hit(idx, IX_IRQ_SET))  rd_sel = SEL_IRQ_MASK;
        else if (hit(idx, IX_SOFT_SET)) rd_sel = SEL_SOFT;
        else if (hit(idx, IX_FIQ_MSKD)) rd_sel = SEL_FIQ_MSKD;
        else if (hit(idx, IX_FIQ_RAW))  rd_sel = SEL_RAW;
        else if (hit(idx, IX_FIQ_SET))  rd_sel = SEL_FIQ_MASK;
    end

    always_comb begin
        wstb = '0;
        wstb.mask_set[LINE_IRQ] = wr && hit(idx, IX_IRQ_SET);
        wstb.mask_clr[LINE_IRQ] = wr && hit(idx, IX_IRQ_CLR);
        wstb.mask_set[LINE_FIQ] = wr && hit(idx, IX_FIQ_SET);
        wstb.mask_clr[LINE_FIQ] = wr && hit(idx, IX_FIQ_CLR);
        wstb.soft_set           = wr && wbit0 && hit(idx, IX_SOFT_SET);
        wstb.soft_clr           = wr && wbit0 && hit(idx, IX_SOFT_CLR);
    end

endmodule

// File: rtl/intc_mask_reg.sv
module intc_mask_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] bits,
    output logic [W-1:0] mask_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (set_en) begin
            mask_q <= mask_q | bits;
        end else if (clr_en) begin
            mask_q <= mask_q & ~bits;
        end
    end

    // R2 and R3: bits written to the set address are ones afterwards
    p_set_sticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ((mask_q & $past(bits)) == $past(bits)));

    // R2 and R3: bits written to the clear address are zeros afterwards
    p_clr_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en) |=> ((mask_q & $past(bits)) == '0));

    // R9: no strobe, no change
    p_mask_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en && !clr_en) |=> $stable(mask_q));

endmodule

// File: rtl/intc_soft_latch.sv
module intc_soft_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic soft_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            soft_q <= 1'b0;
        end else if (clr_req) begin
            soft_q <= 1'b0;
        end else if (set_req) begin
            soft_q <= 1'b1;
        end
    end

    p_soft_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req && !clr_req) |=> soft_q);

    p_soft_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> !soft_q);

    p_soft_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_req && !clr_req) |=> $stable(soft_q));

endmodule

// File: rtl/dual_intc.sv
module dual_intc
    import dual_intc_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_i,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [IDX_W-1:0] bus_idx,
    input  logic [NSRC-1:0]  bus_wdata,
    output logic [NSRC-1:0]  bus_rdata,
    output logic             irq_o,
    output logic             fiq_o
);

    localparam logic [NSRC-1:0] BIT0 = NSRC'(1);

    rd_sel_e              rd_sel;
    wr_strobe_t           wstb;
    logic                 soft_q;
    logic [NSRC-1:0]      raw;
    logic [NSRC-1:0]      mask_q [NUM_LINES];
    logic [NUM_LINES-1:0] line_q;
    logic [NSRC-1:0]      rd_val;

    intc_decode #(.IDX_W(IDX_W)) u_dec (
        .wr     (bus_wr),
        .idx    (bus_idx),
        .wbit0  (bus_wdata[0]),
        .rd_sel (rd_sel),
        .wstb   (wstb)
    );

    intc_soft_latch u_soft (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (wstb.soft_set),
        .clr_req (wstb.soft_clr),
        .soft_q  (soft_q)
    );

    assign raw = src_i | (soft_q ? BIT0 : '0);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        intc_mask_reg #(.W(NSRC)) u_mask (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_en (wstb.mask_set[g]),
            .clr_en (wstb.mask_clr[g]),
            .bits   (bus_wdata),
            .mask_q (mask_q[g])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                line_q[g] <= 1'b0;
            end else begin
                line_q[g] <= |(raw & mask_q[g]);
            end
        end
    end

    assign irq_o = line_q[LINE_IRQ];
    assign fiq_o = line_q[LINE_FIQ];

    always_comb begin
        case (rd_sel)
            SEL_IRQ_MSKD: rd_val = raw & mask_q[LINE_IRQ];
            SEL_RAW:      rd_val = raw;
            SEL_IRQ_MASK: rd_val = mask_q[LINE_IRQ];
            SEL_SOFT:     rd_val = raw & BIT0;
            SEL_FIQ_MSKD: rd_val = raw & mask_q[LINE_FIQ];
            SEL_FIQ_MASK: rd_val = mask_q[LINE_FIQ];
            default:      rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_val;
        end
    end

    // R7: with an empty IRQ mask the request line stays low
    p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q[LINE_IRQ] == '0) |=> !irq_o);

    // R8: with an empty FIQ mask the request line stays low
    p_fiq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q[LINE_FIQ] == '0) |=> !fiq_o);

    // R9: the IRQ clear address reads as zero
    p_clr_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && int'(bus_idx) == IX_IRQ_CLR) |=> (bus_rdata == '0));

    // R10: read data holds between reads
    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R6: soft status read shows bit 0 only
    p_soft_read_bit0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && int'(bus_idx) == IX_SOFT_SET) |=> ((bus_rdata & ~BIT0) == '0));

endmodule

// File: tb/dual_intc_test.sv
`timescale 1ns/1ps
module dual_intc_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_idx = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic        fiq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dual_intc uut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_idx(bus_idx), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    typedef struct packed {
        logic        rd;
        logic [3:0]  idx;
        logic [31:0] data;
        logic [31:0] src;
        logic [31:0] exp;
        logic        eirq;
        logic        efiq;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 38;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 4'd2,  32'h0,        32'h0,        32'h0,        1'b0, 1'b0, 4'd1},  // R1
        '{1'b0, 4'd2,  32'h000000F0, 32'h0,        32'h0,        1'b0, 1'b0, 4'd2},  // R2
        '{1'b1, 4'd2,  32'h0,        32'h0,        32'h000000F0, 1'b0, 1'b0, 4'd2},
        '{1'b0, 4'd2,  32'h0F000000, 32'h0,        32'h0,        1'b0, 1'b0, 4'd2},
        '{1'b1, 4'd2,  32'h0,        32'h0,        32'h0F0000F0, 1'b0, 1'b0, 4'd2},
        '{1'b0, 4'd3,  32'h00000030, 32'h0,        32'h0,        1'b0, 1'b0, 4'd2},
        '{1'b1, 4'd2,  32'h0,        32'h0,        32'h0F0000C0, 1'b0, 1'b0, 4'd2},
        '{1'b1, 4'd1,  32'h0,        32'h00000040, 32'h00000040, 1'b1, 1'b0, 4'd4},  // R4 R7
        '{1'b1, 4'd0,  32'h0,        32'h00000041, 32'h00000040, 1'b1, 1'b0, 4'd5},  // R5
        '{1'b0, 4'd10, 32'h00000001, 32'h00000041, 32'h0,        1'b1, 1'b1, 4'd8},  // R8
        '{1'b1, 4'd8,  32'h0,        32'h00000041, 32'h00000001, 1'b1, 1'b1, 4'd5},
        '{1'b1, 4'd10, 32'h0,        32'h00000041, 32'h00000001, 1'b1, 1'b1, 4'd3},  // R3
        '{1'b0, 4'd4,  32'h00000001, 32'h0,        32'h0,        1'b0, 1'b1, 4'd6},  // R6
        '{1'b1, 4'd4,  32'h0,        32'h80000000, 32'h00000001, 1'b0, 1'b1, 4'd6},
        '{1'b1, 4'd9,  32'h0,        32'h80000000, 32'h80000001, 1'b0, 1'b1, 4'd4},
        '{1'b0, 4'd5,  32'hFFFFFFFE, 32'h0,        32'h0,        1'b0, 1'b1, 4'd6},
        '{1'b1, 4'd4,  32'h0,        32'h0,        32'h00000001, 1'b0, 1'b1, 4'd6},
        '{1'b0, 4'd5,  32'h00000001, 32'h0,        32'h0,        1'b0, 1'b0, 4'd6},
        '{1'b1, 4'd4,  32'h0,        32'h0,        32'h0,        1'b0, 1'b0, 4'd6},
        '{1'b0, 4'd4,  32'hFFFFFFFE, 32'h0,        32'h0,        1'b0, 1'b0, 4'd6},
        '{1'b1, 4'd4,  32'h0,        32'h0,        32'h0,        1'b0, 1'b0, 4'd6},
        '{1'b0, 4'd0,  32'hFFFFFFFF, 32'h0,        32'h0,        1'b0, 1'b0, 4'd9},  // R9
        '{1'b0, 4'd1,  32'hFFFFFFFF, 32'h0,        32'h0,        1'b0, 1'b0, 4'd9},
        '{1'b0, 4'd8,  32'hFFFFFFFF, 32'h0,        32'h0,        1'b0, 1'b0, 4'd9},
        '{1'b0, 4'd9,  32'hFFFFFFFF, 32'h0,        32'h0,        1'b0, 1'b0, 4'd9},
        '{1'b0, 4'd15, 32'hFFFFFFFF, 32'h0,        32'h0,        1'b0, 1'b0, 4'd9},
        '{1'b1, 4'd2,  32'h0,        32'h0,        32'h0F0000C0, 1'b0, 1'b0, 4'd9},
        '{1'b1, 4'd10, 32'h0,        32'h0,        32'h00000001, 1'b0, 1'b0, 4'd9},
        '{1'b1, 4'd4,  32'h0,        32'h0,        32'h0,        1'b0, 1'b0, 4'd9},
        '{1'b1, 4'd3,  32'h0,        32'h0,        32'h0,        1'b0, 1'b0, 4'd9},
        '{1'b1, 4'd5,  32'h0,        32'h0,        32'h0,        1'b0, 1'b0, 4'd9},
        '{1'b1, 4'd11, 32'h0,        32'h0,        32'h0,        1'b0, 1'b0, 4'd9},
        '{1'b1, 4'd15, 32'h0,        32'h0,        32'h0,        1'b0, 1'b0, 4'd9},
        '{1'b0, 4'd11, 32'hFFFFFFFF, 32'h0,        32'h0,        1'b0, 1'b0, 4'd3},
        '{1'b1, 4'd10, 32'h0,        32'h0,        32'h0,        1'b0, 1'b0, 4'd3},
        '{1'b0, 4'd3,  32'hFFFFFFFF, 32'h0,        32'h0,        1'b0, 1'b0, 4'd2},
        '{1'b1, 4'd2,  32'h0,        32'h0,        32'h0,        1'b0, 1'b0, 4'd2},
        '{1'b1, 4'd1,  32'h0,        32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 1'b0, 4'd4}
    };

    task automatic chk(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Access at the next negedge; returns at the negedge after the following edge.
    task automatic access(input logic rd, input logic [3:0] idx, input logic [31:0] d);
        @(negedge clk);
        bus_rd = rd; bus_wr = ~rd; bus_idx = idx; bus_wdata = d;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        @(negedge clk);
    endtask

    task automatic finish_up;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(1, "irq after reset", {31'b0, irq_o}, 32'h0);
        chk(1, "fiq after reset", {31'b0, fiq_o}, 32'h0);
        chk(1, "rdata after reset", bus_rdata, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            src_i = VEC[i].src;
            access(VEC[i].rd, VEC[i].idx, VEC[i].data);
            if (VEC[i].rd) chk(int'(VEC[i].req), $sformatf("vec %0d rdata", i), bus_rdata, VEC[i].exp);
            chk(int'(VEC[i].req), $sformatf("vec %0d irq", i), {31'b0, irq_o}, {31'b0, VEC[i].eirq});
            chk(int'(VEC[i].req), $sformatf("vec %0d fiq", i), {31'b0, fiq_o}, {31'b0, VEC[i].efiq});
        end

        // R7: irq rises one edge after the mask-storing edge
        src_i = 32'h00000100;
        @(negedge clk);
        bus_wr = 1'b1; bus_idx = 4'd2; bus_wdata = 32'h00000100;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
        chk(7, "irq one edge after mask write", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        chk(7, "irq two edges after mask write", {31'b0, irq_o}, 32'h1);
        src_i = 32'h0;
        @(negedge clk);
        chk(7, "irq drops with source", {31'b0, irq_o}, 32'h0);

        // R10: read data holds through idle cycles
        access(1'b1, 4'd2, 32'h0);
        chk(10, "read of irq mask", bus_rdata, 32'h00000100);
        src_i = 32'hFFFFFFFF;
        repeat (3) @(negedge clk);
        chk(10, "rdata held", bus_rdata, 32'h00000100);

        // R8: fiq source on bit 0 through hardware input
        access(1'b0, 4'd10, 32'h00000001);
        chk(8, "fiq with hw src0", {31'b0, fiq_o}, 32'h1);

        // R1: reset mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(1, "irq in reset", {31'b0, irq_o}, 32'h0);
        chk(1, "fiq in reset", {31'b0, fiq_o}, 32'h0);
        chk(1, "rdata in reset", bus_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        access(1'b1, 4'd2, 32'h0);
        chk(1, "irq mask after reset", bus_rdata, 32'h0);
        access(1'b1, 4'd10, 32'h0);
        chk(1, "fiq mask after reset", bus_rdata, 32'h0);
        src_i = 32'h0;
        access(1'b1, 4'd4, 32'h0);
        chk(1, "soft latch after reset", bus_rdata, 32'h0);

        finish_up();
    end

endmodule